// File: doc/BRIEF.md
# Timer and Watchdog with a Shared Prescaler

This block combines an 8-bit free-running timer/counter with a watchdog timer. The two share one programmable power-of-two prescaler. A control register holds three settings: a routing bit that gives the prescaler to either the timer or the watchdog, a 3-bit ratio field, and a watchdog enable. The unit that does not own the prescaler counts its own tick source directly. The timer counts instruction-clock enables (`insn_tick`). The watchdog counts a slow, independent tick (`wd_tick`), which keeps arriving while the instruction clock is stopped during sleep.

When the timer rolls over from all-ones to zero, it sets a sticky overflow flag. Software can clear that flag but cannot set it. When the watchdog reaches its terminal count, it raises a one-cycle reset request for the surrounding chip. Software reaches the block through a simple write/read register port. A dedicated strobe clears the watchdog, and a second strobe marks entry into sleep.

All logic runs on one always-on clock. The tick inputs are single-cycle enables in that clock domain.

Top module: `tmrwd_top`

## Requirements
- R1: After reset, the timer reads 0, the control register reads 0, the overflow flag is 0, the prescaler and watchdog count are 0, and `wd_rst_req` is low.
- R2: The control register (address 1) has these fields: bits [2:0] = ratio r, bit 3 = route (0 timer, 1 watchdog), bit 4 = watchdog enable, bits [7:5] stored but unused. With route 0, the timer advances once per 2^(r+1) `insn_tick` pulses and the watchdog advances once per `wd_tick`. The prescaler divides by comparing its count against the terminal value with a greater-or-equal test, so lowering r never strands the count.
- R3: With route 1, the watchdog advances once per 2^r `wd_tick` pulses and the timer advances once per `insn_tick`.
- R4: A write to address 0 loads the timer with `wr_data` and clears the prescaler count. It is the only register write that clears the prescaler, and it takes precedence over a timer advance in the same cycle.
- R5: When the timer advances from 0xFF, it wraps to 0x00 and sets the overflow flag. A write to address 2 with bit 0 = 0 clears the flag. Writing bit 0 = 1 leaves the flag unchanged. An overflow in the same cycle as a clear leaves the flag set.
- R6: With the watchdog enabled, the WD_BASE-th watchdog advance (default 18) drives `wd_rst_req` high for exactly one cycle and restarts the watchdog count from 0.
- R7: With the watchdog disabled, its count is held at 0 and `wd_rst_req` stays low, whatever ticks arrive.
- R8: A `wd_clr` pulse zeroes the watchdog count. It also zeroes the prescaler when route = 1, and leaves the prescaler untouched when route = 0.
- R9: A `sleep_in` pulse while the watchdog is enabled clears the watchdog count, and also the prescaler when route = 1. The watchdog then keeps counting `wd_tick` with no `insn_tick` present, and can still expire.
- R10: `rd_data` combinationally returns the timer (address 0), the control register (address 1), the flag in bit 0 (address 2), or zero (address 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_tick | input | 1 | Instruction-clock enable, absent during sleep |
| wd_tick | input | 1 | Slow watchdog tick enable |
| sleep_in | input | 1 | Pulse on entry to sleep |
| wd_clr | input | 1 | Watchdog clear strobe |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Write address (0 timer, 1 control, 2 flag) |
| wr_data | input | TMR_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | TMR_W | Read data |
| ovf_flag | output | 1 | Sticky timer overflow flag |
| wd_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The hardest situation to reach from the ports is a collision between prescaler owners. Examples are a `wd_clr` or sleep entry arriving while the prescaler is mid-count for the timer, or the ratio being lowered below the current prescaler count. Each of these needs a specific route setting, a partially advanced prescaler and a precisely timed strobe. Directed sequences first build up a known prescaler count and then fire the strobe, the ratio change or a flag clear on the exact overflow cycle. A long random phase then mixes route flips, ratio rewrites and clears against a cycle-accurate reference model kept in the bench.

// File: rtl/tmrwd_pkg.sv
// Package: shared types and constants for the timer/watchdog/prescaler unit.
// Assumes an 8-bit control register and a 3-bit ratio field.
package tmrwd_pkg;

    localparam int RATIO_W = 3;
    // Prescaler wide enough for the largest divisor 2^(2^RATIO_W).
    localparam int PS_W    = 2 ** RATIO_W;

    typedef enum logic [1:0] {
        REG_TMR  = 2'd0,
        REG_CTRL = 2'd1,
        REG_FLAG = 2'd2,
        REG_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [2:0]         spare;
        logic               wd_en;
        logic               route_wd;
        logic [RATIO_W-1:0] ratio;
    } ctrl_t;

endpackage

// File: rtl/tmrwd_prescaler.sv
// Module: programmable power-of-two prescaler.
// Counts src_tick and emits one pulse per divisor's worth of ticks.
// Divisor is 2^ratio when serving the watchdog, 2^(ratio+1) for the timer.
// Assumes clr has priority over counting; wraps with a >= test so a
// lowered ratio takes effect on the next tick.
module tmrwd_prescaler
    import tmrwd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_tick,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               route_wd,
    input  logic               clr,
    output logic               pulse,
    output logic [PS_W-1:0]    count
);

    logic [RATIO_W:0] shamt;
    logic [PS_W:0]    divisor;
    logic [PS_W:0]    div_m1;
    logic [PS_W-1:0]  terminal;

    // Derive the terminal count from ratio and route.
    always_comb begin
        shamt    = {1'b0, ratio} + {{RATIO_W{1'b0}}, ~route_wd};
        divisor  = (PS_W+1)'(1) << shamt;
        div_m1   = divisor - (PS_W+1)'(1);
        terminal = div_m1[PS_W-1:0];
        pulse    = src_tick && (count >= terminal);
    end

    // Count source ticks, wrap at terminal, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (src_tick) begin
            count <= pulse ? '0 : count + PS_W'(1);
        end
    end

endmodule

// File: rtl/tmrwd_timer.sv
// Module: free-running timer/counter with sticky overflow flag.
// Assumes load beats increment; an overflow beats a software clear;
// the flag can never be set by software.
module tmrwd_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             flag_clr,
    output logic [TMR_W-1:0] count,
    output logic             flag
);

    logic wrap;

    // Detect rollover from all-ones on an accepted increment.
    always_comb wrap = inc && !load && (count == {TMR_W{1'b1}});

    // Load or advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (inc) begin
            count <= count + TMR_W'(1);
        end
    end

    // Maintain the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (wrap) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/tmrwd_watchdog.sv
// Module: watchdog counter with one-cycle reset request.
// Expires on the WD_BASE-th advance while enabled, then restarts.
// Assumes disable or clear holds the count at zero.
module tmrwd_watchdog #(
    parameter int WD_BASE = 18,
    parameter int WD_W    = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            adv,
    input  logic            clr,
    output logic [WD_W-1:0] count,
    output logic            rst_req
);

    localparam logic [WD_W-1:0] LAST = WD_W'(WD_BASE - 1);

    logic expire;

    // Terminal advance while enabled and not being cleared.
    always_comb expire = en && !clr && adv && (count == LAST);

    // Advance, clear or hold the watchdog count.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || clr) begin
            count <= '0;
        end else if (adv) begin
            count <= expire ? '0 : count + WD_W'(1);
        end
    end

    // Register the one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= expire;
        end
    end

endmodule

// File: rtl/tmrwd_top.sv
// Module: timer + watchdog sharing one prescaler, with register port.
// Control bits: [2:0] ratio, [3] route to watchdog, [4] watchdog enable.
// Assumes TMR_W >= 8 so the control register fits the data bus, and
// tick inputs are single-cycle enables on the always-on clock.
module tmrwd_top
    import tmrwd_pkg::*;
#(
    parameter int TMR_W   = 8,
    parameter int WD_BASE = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_tick,
    input  logic             wd_tick,
    input  logic             sleep_in,
    input  logic             wd_clr,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [TMR_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [TMR_W-1:0] rd_data,
    output logic             ovf_flag,
    output logic             wd_rst_req
);

    localparam int WD_W = (WD_BASE > 1) ? $clog2(WD_BASE) : 1;

    ctrl_t            ctrl_q;
    logic             tmr_load, flag_clr, ctrl_wr;
    logic             ps_src, ps_clr, ps_pulse;
    logic             tmr_inc, wd_adv, wd_clear;
    logic [PS_W-1:0]  ps_q;
    logic [TMR_W-1:0] tmr_q;
    logic [WD_W-1:0]  wd_cnt;

    // Decode writes and route ticks between timer and watchdog.
    always_comb begin
        tmr_load = wr_en && (wr_addr == REG_TMR);
        ctrl_wr  = wr_en && (wr_addr == REG_CTRL);
        flag_clr = wr_en && (wr_addr == REG_FLAG) && !wr_data[0];
        wd_clear = wd_clr || (sleep_in && ctrl_q.wd_en);
        ps_src   = ctrl_q.route_wd ? wd_tick : insn_tick;
        ps_clr   = tmr_load || (ctrl_q.route_wd && wd_clear);
        tmr_inc  = ctrl_q.route_wd ? insn_tick : ps_pulse;
        wd_adv   = ctrl_q.route_wd ? ps_pulse : wd_tick;
    end

    // Hold the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_t'(wr_data[7:0]);
        end
    end

    tmrwd_prescaler u_ps (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (ps_src),
        .ratio    (ctrl_q.ratio),
        .route_wd (ctrl_q.route_wd),
        .clr      (ps_clr),
        .pulse    (ps_pulse),
        .count    (ps_q)
    );

    tmrwd_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (tmr_inc),
        .load     (tmr_load),
        .load_val (wr_data),
        .flag_clr (flag_clr),
        .count    (tmr_q),
        .flag     (ovf_flag)
    );

    tmrwd_watchdog #(.WD_BASE(WD_BASE), .WD_W(WD_W)) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl_q.wd_en),
        .adv     (wd_adv),
        .clr     (wd_clear),
        .count   (wd_cnt),
        .rst_req (wd_rst_req)
    );

    // Select the register returned on the read port.
    always_comb begin
        unique case (rd_addr)
            REG_TMR:  rd_data = tmr_q;
            REG_CTRL: rd_data = TMR_W'(ctrl_q);
            REG_FLAG: rd_data = TMR_W'(ovf_flag);
            default:  rd_data = '0;
        endcase
    end

endmodule

// Module: property checker for tmrwd_top, attached by bind below.
// Assumes it sees the top's internal timer, prescaler and watchdog counts.
module tmrwd_chk #(
    parameter int TMR_W = 8,
    parameter int PS_W  = 8,
    parameter int WD_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [TMR_W-1:0] wr_data,
    input logic             wd_clr,
    input logic [7:0]       ctrl_q,
    input logic [TMR_W-1:0] tmr_q,
    input logic [PS_W-1:0]  ps_q,
    input logic [WD_W-1:0]  wd_cnt,
    input logic             ovf_flag,
    input logic             wd_rst_req
);

    // R4
    tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0) |=> (ps_q == '0 && tmr_q == $past(wr_data)));

    // R5
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_flag && tmr_q != {TMR_W{1'b1}}) |=> !ovf_flag);

    // R5
    flag_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (tmr_q == '0));

    // R6
    wd_req_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req |-> ($past(ctrl_q[4]) && wd_cnt == '0));

    // R7
    wd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[4] |=> (!wd_rst_req && wd_cnt == '0));

    // R8
    wd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_clr |=> (wd_cnt == '0));

    // R8
    wd_clr_ps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_clr && ctrl_q[3]) |=> (ps_q == '0));

endmodule

bind tmrwd_top tmrwd_chk #(
    .TMR_W (TMR_W),
    .PS_W  (tmrwd_pkg::PS_W),
    .WD_W  (WD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wd_clr     (wd_clr),
    .ctrl_q     (ctrl_q),
    .tmr_q      (tmr_q),
    .ps_q       (ps_q),
    .wd_cnt     (wd_cnt),
    .ovf_flag   (ovf_flag),
    .wd_rst_req (wd_rst_req)
);

// File: tb/tmrwd_top_tb_top.sv
// Bench: directed corners plus seeded random stimulus, checked against a
// cycle model built from the requirements.
module tmrwd_top_tb_top;

    localparam int WD_BASE = 18;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       insn_tick = 1'b0, wd_tick = 1'b0, sleep_in = 1'b0, wd_clr = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       ovf_flag, wd_rst_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Reference model state.
    int       m_tmr, m_ps, m_wd;
    bit       m_flag, m_req;
    bit [7:0] m_ctrl;

    always #10 clk = ~clk;

    tmrwd_top #(.TMR_W(8), .WD_BASE(WD_BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .insn_tick(insn_tick), .wd_tick(wd_tick),
        .sleep_in(sleep_in), .wd_clr(wd_clr), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ovf_flag(ovf_flag), .wd_rst_req(wd_rst_req)
    );

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_tmr = 0; m_ps = 0; m_wd = 0; m_flag = 0; m_req = 0; m_ctrl = 8'h00;
    endtask

    // One clock of the reference model, from current bench inputs.
    task automatic model_update();
        bit route = m_ctrl[3];
        bit en    = m_ctrl[4];
        int r     = int'(m_ctrl[2:0]);
        int d     = route ? (1 << r) : (1 << (r + 1));
        bit src   = route ? wd_tick : insn_tick;
        bit pulse = src && (m_ps >= d - 1);
        bit tload = wr_en && wr_addr == 2'd0;
        bit wclr  = wd_clr || (sleep_in && en);
        bit tinc  = route ? insn_tick : pulse;
        bit winc  = route ? pulse : wd_tick;
        bit wrap  = tinc && !tload && m_tmr == 255;
        if (tload || (route && wclr)) m_ps = 0;
        else if (src) m_ps = pulse ? 0 : m_ps + 1;
        if (tload) m_tmr = int'(wr_data);
        else if (tinc) m_tmr = (m_tmr + 1) % 256;
        if (wrap) m_flag = 1;
        else if (wr_en && wr_addr == 2'd2 && !wr_data[0]) m_flag = 0;
        m_req = 0;
        if (!en || wclr) m_wd = 0;
        else if (winc) begin
            if (m_wd == WD_BASE - 1) begin m_wd = 0; m_req = 1; end
            else m_wd = m_wd + 1;
        end
        if (wr_en && wr_addr == 2'd1) m_ctrl = wr_data;
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        #1;
        chk(int'(ovf_flag), int'(m_flag), tag);
        chk(int'(wd_rst_req), int'(m_req), tag);
    endtask

    task automatic chk_regs(input string tag);
        rd_addr = 2'd0; #1; chk(int'(rd_data), m_tmr, tag);
        rd_addr = 2'd1; #1; chk(int'(rd_data), int'(m_ctrl), tag);
        rd_addr = 2'd2; #1; chk(int'(rd_data), int'(m_flag), tag);
        rd_addr = 2'd3; #1; chk(int'(rd_data), 0, tag);
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] dt, input string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = dt;
        step(tag);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n, input bit ins, input bit wdt, input string tag);
        for (int i = 0; i < n; i++) begin
            insn_tick = ins; wd_tick = wdt;
            step(tag);
        end
        insn_tick = 1'b0; wd_tick = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL timeout R1..all: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(int'(wd_rst_req), 0, "R1");
        chk_regs("R1");

        // R10 read-back of control
        do_write(2'd1, 8'hF5, "R10");
        chk_regs("R10");

        // R2 timer divided by 4 (r=1, route timer)
        do_write(2'd1, 8'h01, "R2");
        do_write(2'd0, 8'h10, "R4");
        ticks(9, 1'b1, 1'b0, "R2");
        chk_regs("R2");

        // R4 timer write clears partial prescaler count
        ticks(3, 1'b1, 1'b0, "R4");
        do_write(2'd0, 8'h20, "R4");
        ticks(4, 1'b1, 1'b0, "R4");
        chk_regs("R4");
        insn_tick = 1'b1;
        do_write(2'd0, 8'h33, "R4");
        insn_tick = 1'b0;
        chk_regs("R4");

        // R5 overflow, clear, no software set, overflow beats clear
        do_write(2'd1, 8'h00, "R5");
        do_write(2'd0, 8'hFE, "R5");
        ticks(4, 1'b1, 1'b0, "R5");
        chk_regs("R5");
        do_write(2'd2, 8'h00, "R5");
        chk_regs("R5");
        do_write(2'd2, 8'hFF, "R5");
        chk_regs("R5");
        do_write(2'd0, 8'hFF, "R5");
        ticks(1, 1'b1, 1'b0, "R5");
        insn_tick = 1'b1;
        do_write(2'd2, 8'h00, "R5");
        insn_tick = 1'b0;
        chk_regs("R5");
        do_write(2'd2, 8'h00, "R5");

        // R3 / R6 prescaler on watchdog, ratio 4
        do_write(2'd1, 8'h1A, "R3");
        wd_clr = 1'b1; step("R8"); wd_clr = 1'b0;
        ticks(5, 1'b1, 1'b0, "R3");
        chk_regs("R3");
        ticks(WD_BASE * 4 + 2, 1'b0, 1'b1, "R6");

        // R6 watchdog without prescaler
        do_write(2'd1, 8'h10, "R6");
        ticks(WD_BASE + 3, 1'b0, 1'b1, "R6");

        // R7 disabled watchdog never fires
        do_write(2'd1, 8'h08, "R7");
        ticks(120, 1'b0, 1'b1, "R7");
        do_write(2'd1, 8'h00, "R7");
        ticks(60, 1'b1, 1'b1, "R7");

        // R8 clear restarts watchdog; route timer keeps prescaler
        do_write(2'd1, 8'h11, "R8");
        ticks(10, 1'b0, 1'b1, "R8");
        wd_clr = 1'b1; step("R8"); wd_clr = 1'b0;
        ticks(WD_BASE + 1, 1'b0, 1'b1, "R8");
        do_write(2'd0, 8'h40, "R8");
        ticks(2, 1'b1, 1'b0, "R8");
        wd_clr = 1'b1; step("R8"); wd_clr = 1'b0;
        ticks(2, 1'b1, 1'b0, "R8");
        chk_regs("R8");

        // R9 sleep entry clears watchdog, keeps running on slow tick only
        do_write(2'd1, 8'h10, "R9");
        ticks(10, 1'b0, 1'b1, "R9");
        sleep_in = 1'b1; step("R9"); sleep_in = 1'b0;
        ticks(WD_BASE + 2, 1'b0, 1'b1, "R9");
        do_write(2'd1, 8'h19, "R9");
        ticks(1, 1'b0, 1'b1, "R9");
        sleep_in = 1'b1; step("R9"); sleep_in = 1'b0;
        ticks(WD_BASE * 2 + 2, 1'b0, 1'b1, "R9");
        chk_regs("R9");

        // R2 lowering the ratio below the current prescaler count
        do_write(2'd1, 8'h07, "R2");
        do_write(2'd0, 8'h00, "R2");
        ticks(100, 1'b1, 1'b0, "R2");
        do_write(2'd1, 8'h00, "R2");
        ticks(3, 1'b1, 1'b0, "R2");
        chk_regs("R2");

        // Random mix of ticks, writes and strobes
        for (int i = 0; i < 6000; i++) begin
            int sel = int'($urandom % 100);
            insn_tick = ($urandom % 2) == 0;
            wd_tick   = ($urandom % 6) == 0;
            wd_clr    = ($urandom % 300) == 0;
            sleep_in  = ($urandom % 400) == 0;
            wr_en     = sel < 6;
            wr_addr   = 2'($urandom % 3);
            wr_data   = 8'($urandom);
            if (wr_en && wr_addr == 2'd1 && ($urandom % 4) != 0) wr_data[4] = 1'b1;
            if (wr_en && wr_addr == 2'd1) wr_data[2:0] = 3'($urandom % 4);
            step("R2 R3 R5 R6 random");
            if (i % 500 == 0) chk_regs("R10 random");
        end
        insn_tick = 0; wd_tick = 0; wd_clr = 0; sleep_in = 0; wr_en = 0;
        chk_regs("R10 random");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule